// File: doc/BRIEF.md
# Successive Approximation Search Sequencer

This block runs the binary search of a successive-approximation converter. A start pulse begins a conversion. The block then builds an N-bit trial code one bit at a time, beginning at the most significant bit. An external DAC turns each trial code into a voltage, and an external comparator reports whether the sampled input is above that voltage. The block reads this one-bit answer and either keeps the bit under test or clears it, then moves to the next lower bit.

Each bit is also sent out on a serial line, most significant bit first, with a valid strobe, as soon as it is decided. When the last bit is settled, the full parallel code is loaded into a result register and a done pulse is raised. A conversion always takes the same number of cycles, whatever the input value.

Top module: `sar_search_ctrl`

## Requirements
- R1: A start pulse seen while idle clears the trial code to zero and raises busy on the next edge. That first busy cycle is the load cycle, and the trial code is zero throughout it.
- R2: In the cycle after the load cycle, the trial code is exactly the most significant bit set (value 2^(N-1)).
- R3: The comparator input is sampled one edge after each trial code appears. The bit under test is kept at 1 when cmp_i is 1 and cleared to 0 when it is 0. On that same edge the next lower bit is set for the next trial.
- R4: busy_o stays high for exactly N+1 consecutive cycles per conversion (one load cycle plus N compare cycles), for every input value.
- R5: done_o is a one-cycle pulse. It is high in the first cycle with busy_o low, and in that cycle result_o holds the final code.
- R6: result_o changes only when a conversion completes. A new start clears the trial code but leaves result_o unchanged.
- R7: ser_vld_o is high for N consecutive cycles, each in the cycle after one comparison. ser_bit_o carries the decided bit, most significant bit first, and the sequence equals result_o read from bit N-1 down to bit 0.
- R8: A start pulse while busy_o is high is ignored: the sequence, its timing and the result are unchanged.
- R9: After reset, busy_o, done_o, ser_vld_o, trial_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted only when idle |
| cmp_i | input | 1 | Comparator: 1 when the input is above the DAC output |
| trial_o | output | WIDTH | Trial code driven to the DAC |
| busy_o | output | 1 | High for the load cycle and all compare cycles |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Final parallel code, held until the next completion |
| ser_bit_o | output | 1 | Decided bit, most significant bit first |
| ser_vld_o | output | 1 | Qualifies ser_bit_o |

## Verification
Take the start edge as E0. busy_o and the cleared trial code appear after E0, and the MSB-only trial code after E1. The serial bit for bit N-1-k and the updated trial code appear after edge E(2+k). done_o, the final result_o and the fall of busy_o all appear after E(N+1). The bench drives and samples on falling edges and steps through these edges one at a time, so each output is checked in exactly the cycle it is due. The bench models the comparator as an ideal quantizer. It computes the expected code directly as the input level minus one, clamped to the code range, rather than by repeating the search.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CONV = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_ctl_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDXW  = $clog2(WIDTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            busy_o,
  output logic            clear_o,
  output logic            arm_o,
  output logic            decide_o,
  output logic            last_o,
  output logic [IDXW-1:0] idx_o
);
  localparam logic [IDXW-1:0] IDX_TOP = IDXW'(WIDTH - 1);
  localparam logic [IDXW-1:0] IDX_ONE = IDXW'(1);

  sar_state_e state_q;
  logic [IDXW-1:0] idx_q;

  // named internal events
  assign clear_o  = (state_q == ST_IDLE) && start_i;
  assign arm_o    = (state_q == ST_LOAD);
  assign decide_o = (state_q == ST_CONV);
  assign last_o   = decide_o && (idx_q == '0);
  assign busy_o   = (state_q != ST_IDLE);
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_LOAD;
        ST_LOAD: begin
          state_q <= ST_CONV;
          idx_q   <= IDX_TOP;
        end
        ST_CONV: begin
          if (idx_q == '0) state_q <= ST_IDLE;
          else             idx_q   <= idx_q - IDX_ONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: start while converting never restarts the load cycle
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_o && start_i && !last_o) |=> (state_q == ST_CONV));

  // R4: load cycle is always followed by a compare at the top bit
  a_r4_load_then_top: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |=> (decide_o && idx_q == IDX_TOP));

  // R4: index counts down by one while comparing
  a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_o && !last_o) |=> (decide_o && idx_q == $past(idx_q) - IDX_ONE));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 8,
  parameter int IDXW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             arm_i,
  input  logic             decide_i,
  input  logic             last_i,
  input  logic [IDXW-1:0]  idx_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
  localparam logic [WIDTH-1:0] MSB_SET = ONE << (WIDTH - 1);

  // keep-or-clear the bit under test, then arm the next lower bit
  function automatic logic [WIDTH-1:0] sar_step(
    input logic [WIDTH-1:0] cur,
    input logic [IDXW-1:0]  idx,
    input logic             keep
  );
    logic [WIDTH-1:0] nxt;
    nxt = cur;
    nxt[idx] = keep;
    if (idx != '0) nxt[idx - IDXW'(1)] = 1'b1;
    return nxt;
  endfunction

  function automatic logic [WIDTH-1:0] below_mask(input logic [IDXW-1:0] idx);
    return (ONE << idx) - ONE;
  endfunction

  logic [WIDTH-1:0] trial_q, result_q, step_w;
  logic done_q;

  assign step_w = sar_step(trial_q, idx_i, cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_i;
      if (clear_i)       trial_q <= '0;
      else if (arm_i)    trial_q <= MSB_SET;
      else if (decide_i) trial_q <= step_w;
      if (last_i) result_q <= step_w;
    end
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;
  assign done_o   = done_q;

  // R2: first trial is the MSB alone
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (trial_q == MSB_SET));

  // R3: during a compare, bits below the one under test are zero
  a_r3_lower_clear: assert property (@(posedge clk) disable iff (!rst_n)
    decide_i |-> ((trial_q & below_mask(idx_i)) == '0));

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: result moves only on completion
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(result_q));
endmodule

// File: rtl/sar_ser_out.sv
module sar_ser_out (
  input  logic clk,
  input  logic rst_n,
  input  logic decide_i,
  input  logic cmp_i,
  output logic ser_bit_o,
  output logic ser_vld_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_bit_o <= 1'b0;
      ser_vld_o <= 1'b0;
    end else begin
      ser_vld_o <= decide_i;
      if (decide_i) ser_bit_o <= cmp_i;
    end
  end

  // R7: a serial strobe follows every compare cycle
  a_r7_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    decide_i |=> ser_vld_o);
endmodule

// File: rtl/sar_search_ctrl.sv
module sar_search_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             ser_bit_o,
  output logic             ser_vld_o
);
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic clear_w, arm_w, decide_w, last_w;
  logic [IDXW-1:0] idx_w;

  sar_seq_fsm #(.WIDTH(WIDTH), .IDXW(IDXW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .clear_o(clear_w), .arm_o(arm_w), .decide_o(decide_w),
    .last_o(last_w), .idx_o(idx_w)
  );

  sar_trial_reg #(.WIDTH(WIDTH), .IDXW(IDXW)) reg_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .arm_i(arm_w),
    .decide_i(decide_w), .last_i(last_w), .idx_i(idx_w), .cmp_i(cmp_i),
    .trial_o(trial_o), .result_o(result_o), .done_o(done_o)
  );

  sar_ser_out ser_i (
    .clk(clk), .rst_n(rst_n), .decide_i(decide_w), .cmp_i(cmp_i),
    .ser_bit_o(ser_bit_o), .ser_vld_o(ser_vld_o)
  );

  // R5: done coincides with the end of busy
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R1: accepted start raises busy with a zero trial code
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && trial_o == '0));
endmodule

// File: tb/sar_search_ctrl_tb_top.sv
module sar_search_ctrl_tb_top;
  localparam int W = 8;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic [W-1:0] trial, result;
  logic busy, done, ser_bit, ser_vld;
  int vin = 0;
  int n_chk = 0;
  int n_bad = 0;
  int prev_res = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // ideal quantizer: input above DAC level
  assign cmp = (vin > int'(trial));

  sar_search_ctrl #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .trial_o(trial), .busy_o(busy), .done_o(done), .result_o(result),
    .ser_bit_o(ser_bit), .ser_vld_o(ser_vld)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expect_code(input int v);
    if (v <= 0) return 0;
    if (v - 1 > MAXC) return MAXC;
    return v - 1;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 0 && done == 0 && ser_vld == 0, "R9", "flags", {busy, done, ser_vld}, 0);
    chk(trial == 0 && result == 0, "R9", "codes", int'(trial) + int'(result), 0);
    rst_n = 1'b1;
  endtask

  // one conversion, stepped edge by edge; poke issues a start mid-run
  task automatic t_convert(input int v, input bit poke);
    int e = expect_code(v);
    int busy_cnt = 0;
    int ser_word = 0;
    vin = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1 && trial == 0, "R1", "load cycle trial", int'(trial), 0);
    chk(result == W'(prev_res), "R6", "result kept on start", int'(result), prev_res);
    if (busy) busy_cnt++;
    @(negedge clk);
    chk(trial == W'(1 << (W - 1)), "R2", "msb trial", int'(trial), 1 << (W - 1));
    chk(ser_vld == 0, "R7", "no strobe before compare", int'(ser_vld), 0);
    if (busy) busy_cnt++;
    if (poke) start = 1'b1;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      if (poke && k == 0) start = 1'b0;
      chk(ser_vld == 1 && ser_bit == e[W-1-k], "R7", "serial bit",
          int'({ser_vld, ser_bit}), 2 + ((e >> (W - 1 - k)) & 1));
      ser_word = (ser_word << 1) | int'(ser_bit);
      if (busy) busy_cnt++;
      if (k < W - 1) begin
        int hi = e & ~((1 << (W - 1 - k)) - 1);
        int want = hi | (1 << (W - 2 - k));
        chk(int'(trial) == want, poke ? "R8" : "R3", "partial trial", int'(trial), want);
        chk(done == 0, "R5", "no early done", int'(done), 0);
      end else begin
        chk(done == 1 && busy == 0, "R5", "done at end", int'({done, busy}), 2);
        chk(int'(result) == e, poke ? "R8" : "R3", "final code", int'(result), e);
      end
    end
    chk(busy_cnt == W + 1, "R4", "busy span", busy_cnt, W + 1);
    chk(ser_word == e, "R7", "serial word", ser_word, e);
    @(negedge clk);
    chk(done == 0 && ser_vld == 0, "R5", "pulse ends", int'({done, ser_vld}), 0);
    vin = MAXC - v;
    repeat (3) @(negedge clk);
    chk(int'(result) == e, "R6", "result held", int'(result), e);
    prev_res = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_convert(0, 1'b0);
    t_convert(1, 1'b0);
    t_convert(256, 1'b0);
    t_convert(255, 1'b0);
    t_convert(128, 1'b0);
    t_convert(129, 1'b0);
    t_convert(77, 1'b1);
    t_convert(200, 1'b1);
    for (int s = 3; s < 256; s += 37) t_convert(s, 1'b0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule